// File: doc/BRIEF.md
# Flit Link Retry Layer

This block is the link layer of one end of a full-duplex point-to-point link. It carries 80-bit flits. On the transmit side it takes a payload (a message class and 64 data bits) through a valid/ready handshake. It gives the payload the next sequence number, appends an 8-bit CRC and drives the flit out one cycle later. It also keeps a copy of the flit in a retry buffer until the far end acknowledges it.

On the receive side it recomputes the CRC of each arriving flit. A flit that passes the check and carries the expected sequence number is handed out as a payload. When the CRC does not match, the receiver asks the far transmitter, through a small control flit on the return path, to resend from the sequence number it still expects. When the local transmitter gets such a request, it replays its buffered flits in order from that number.

In a system the flit output of one end feeds the flit input of the other, and the two control channels cross over the same way. Tying one instance back to itself therefore forms a complete link.

Top module: `flit_link`

## Requirements
- R1: A flit is laid out as bits 79:72 CRC, bits 71:69 message class, bits 68:64 sequence number and bits 63:0 data.
- R2: The CRC is the remainder of the 72-bit body (bits 71:0) times x^8, divided by x^8+x^2+x+1. The body is taken most significant bit first and the register starts at zero.
- R3: New payloads get consecutive sequence numbers modulo 32, starting at 0 after reset. Each flit appears on `tx_flit` one cycle after its payload is accepted.
- R4: At most DEPTH (8) flits wait for acknowledgement, and `in_ready` is low while that many are held. An acknowledgement carrying sequence s frees every held flit that is older than s.
- R5: A received flit whose CRC does not match is not delivered. In the next cycle a retry request goes out on the return path carrying the sequence number the receiver expects. Every single-bit error in the 80 bits is caught.
- R6: A retry request carrying sequence s makes the transmitter resend its held flits in order, starting from s. No new payload is accepted in the cycle of the request or while the replay runs.
- R7: Payloads are delivered in order and exactly once. A flit whose sequence number is not the expected one is dropped without any response.
- R8: A flit that passes the CRC check, carries the expected sequence number and has class 0 to 5 is delivered on the next cycle. In the same cycle an acknowledgement goes out carrying the next expected sequence number.
- R9: A flit that passes the CRC check but has class 6 or 7 is never delivered, pulses `rx_cls_err` for one cycle and never causes a retry. If its sequence number is the expected one, it still uses up that number and is acknowledged.
- R10: After reset, `in_ready` is high and `tx_flit_valid`, `rx_out_valid`, `ret_out_valid` and `rx_cls_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Payload offered to the transmitter |
| in_ready | output | 1 | Transmitter accepts the payload this cycle |
| in_cls | input | 3 | Message class of the offered payload |
| in_data | input | 64 | Data of the offered payload |
| tx_flit_valid | output | 1 | Outgoing flit present |
| tx_flit | output | 80 | Outgoing flit |
| rx_flit_valid | input | 1 | Incoming flit present |
| rx_flit | input | 80 | Incoming flit |
| rx_out_valid | output | 1 | Delivered payload present |
| rx_out_cls | output | 3 | Class of the delivered payload |
| rx_out_data | output | 64 | Data of the delivered payload |
| rx_cls_err | output | 1 | One-cycle pulse for a flit with a reserved class |
| ret_in_valid | input | 1 | Control flit from the far receiver |
| ret_in_retry | input | 1 | 1 = retry request, 0 = acknowledgement |
| ret_in_seq | input | 5 | Sequence number the far receiver expects |
| ret_out_valid | output | 1 | Control flit to the far transmitter |
| ret_out_retry | output | 1 | 1 = retry request, 0 = acknowledgement |
| ret_out_seq | output | 5 | Sequence number this receiver expects |

## Verification
The bench uses the default DEPTH of 8 with the fixed 5-bit sequence field. With these values, 100 payloads sent in loopback wrap the sequence space three times, and nine offers are enough to find the point where the retry buffer is full. Corrupting every fifth flit in loopback drives retries that overlap with replays still running. Direct injection then sweeps a flipped bit over all 80 positions and all eight class codes, and replays a short window from a chosen sequence number.

// File: rtl/flit_pkg.sv
package flit_pkg;
  localparam int DATA_W = 64;
  localparam int CLS_W  = 3;
  localparam int SEQ_W  = 5;
  localparam int BODY_W = CLS_W + SEQ_W + DATA_W;
  localparam int CRC_W  = 8;
  localparam int FLIT_W = CRC_W + BODY_W;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam logic [CLS_W-1:0] CLS_LAST = 3'd5;

  typedef struct packed {
    logic [CRC_W-1:0]  crc;
    logic [CLS_W-1:0]  cls;
    logic [SEQ_W-1:0]  seq;
    logic [DATA_W-1:0] data;
  } flit_t;

  function automatic logic [CRC_W-1:0] crc_of(input logic [BODY_W-1:0] body);
    logic [CRC_W-1:0] r;
    logic fb;
    r = '0;
    for (int i = BODY_W - 1; i >= 0; i--) begin
      fb = r[CRC_W-1] ^ body[i];
      r  = {r[CRC_W-2:0], 1'b0};
      if (fb) r = r ^ CRC_POLY;
    end
    return r;
  endfunction

  function automatic logic cls_reserved(input logic [CLS_W-1:0] c);
    return c > CLS_LAST;
  endfunction

  function automatic flit_t seal(input logic [BODY_W-1:0] body);
    flit_t f;
    f = flit_t'({crc_of(body), body});
    return f;
  endfunction
endpackage

// File: rtl/flit_tx.sv
module flit_tx
  import flit_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        in_valid,
  output logic                        in_ready,
  input  logic [CLS_W-1:0]            in_cls,
  input  logic [DATA_W-1:0]           in_data,
  output logic                        flit_valid,
  output logic [FLIT_W-1:0]           flit,
  input  logic                        ctl_valid,
  input  logic                        ctl_retry,
  input  logic [SEQ_W-1:0]            ctl_seq,
  output logic [$clog2(DEPTH+1)-1:0]  occ,
  output logic                        replaying
);
  localparam int IW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  logic [SEQ_W-1:0]  head_q, next_q, send_q;
  logic [BODY_W-1:0] keep_q [DEPTH];
  logic [SEQ_W-1:0]  held, ctl_off, send_off;
  logic              in_win, retry_hit, ack_hit, full, accept, replay_go;
  logic [BODY_W-1:0] body;

  always_comb begin
    held      = next_q - head_q;
    ctl_off   = ctl_seq - head_q;
    send_off  = send_q - head_q;
    in_win    = ctl_off <= held;
    retry_hit = ctl_valid && ctl_retry && in_win;
    ack_hit   = ctl_valid && !ctl_retry && in_win;
    full      = held == SEQ_W'(DEPTH);
    replaying = send_q != next_q;
    in_ready  = !full && !replaying && !retry_hit;
    accept    = in_valid && in_ready;
    replay_go = replaying && !retry_hit;
    body      = accept ? {in_cls, next_q, in_data} : keep_q[send_q[IW-1:0]];
    occ       = CW'(held);
  end

  always_ff @(posedge clk) begin
    if (accept) keep_q[next_q[IW-1:0]] <= body;
  end

  always_ff @(posedge clk) begin
    if (accept || replay_go) flit <= seal(body);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head_q     <= '0;
      next_q     <= '0;
      send_q     <= '0;
      flit_valid <= 1'b0;
    end else begin
      flit_valid <= accept || replay_go;
      if (accept) next_q <= next_q + 1'b1;
      if (retry_hit) begin
        head_q <= ctl_seq;
        send_q <= ctl_seq;
      end else begin
        if (accept || replay_go) send_q <= send_q + 1'b1;
        if (ack_hit) begin
          head_q <= ctl_seq;
          if (ctl_off > send_off) send_q <= ctl_seq;
        end
      end
    end
  end
endmodule

// File: rtl/flit_rx.sv
module flit_rx
  import flit_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flit_valid,
  input  logic [FLIT_W-1:0] flit,
  output logic              out_valid,
  output logic [CLS_W-1:0]  out_cls,
  output logic [DATA_W-1:0] out_data,
  output logic              cls_err,
  output logic              ctl_valid,
  output logic              ctl_retry,
  output logic [SEQ_W-1:0]  ctl_seq,
  output logic [SEQ_W-1:0]  exp_seq,
  output logic              crc_bad
);
  flit_t f;
  logic  good, in_order, deliver, reserved;

  always_comb begin
    f        = flit_t'(flit);
    reserved = cls_reserved(f.cls);
    crc_bad  = flit_valid && (f.crc != crc_of(flit[BODY_W-1:0]));
    good     = flit_valid && !crc_bad;
    in_order = good && (f.seq == exp_seq);
    deliver  = in_order && !reserved;
  end

  always_ff @(posedge clk) begin
    if (deliver) begin
      out_cls  <= f.cls;
      out_data <= f.data;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_seq   <= '0;
      out_valid <= 1'b0;
      cls_err   <= 1'b0;
      ctl_valid <= 1'b0;
      ctl_retry <= 1'b0;
      ctl_seq   <= '0;
    end else begin
      out_valid <= deliver;
      cls_err   <= good && reserved;
      ctl_valid <= crc_bad || in_order;
      ctl_retry <= crc_bad;
      ctl_seq   <= crc_bad ? exp_seq : exp_seq + 1'b1;
      if (in_order) exp_seq <= exp_seq + 1'b1;
    end
  end
endmodule

// File: rtl/flit_link.sv
module flit_link
  import flit_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_cls,
  input  logic [63:0]       in_data,
  output logic              tx_flit_valid,
  output logic [79:0]       tx_flit,
  input  logic              rx_flit_valid,
  input  logic [79:0]       rx_flit,
  output logic              rx_out_valid,
  output logic [2:0]        rx_out_cls,
  output logic [63:0]       rx_out_data,
  output logic              rx_cls_err,
  input  logic              ret_in_valid,
  input  logic              ret_in_retry,
  input  logic [4:0]        ret_in_seq,
  output logic              ret_out_valid,
  output logic              ret_out_retry,
  output logic [4:0]        ret_out_seq
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0]    tx_occ;
  logic             tx_replay;
  logic [SEQ_W-1:0] rx_exp;
  logic             rx_crc_bad;

  flit_tx #(.DEPTH(DEPTH)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_cls(in_cls), .in_data(in_data),
    .flit_valid(tx_flit_valid), .flit(tx_flit),
    .ctl_valid(ret_in_valid), .ctl_retry(ret_in_retry), .ctl_seq(ret_in_seq),
    .occ(tx_occ), .replaying(tx_replay)
  );

  flit_rx u_rx (
    .clk(clk), .rst_n(rst_n),
    .flit_valid(rx_flit_valid), .flit(rx_flit),
    .out_valid(rx_out_valid), .out_cls(rx_out_cls), .out_data(rx_out_data),
    .cls_err(rx_cls_err),
    .ctl_valid(ret_out_valid), .ctl_retry(ret_out_retry), .ctl_seq(ret_out_seq),
    .exp_seq(rx_exp), .crc_bad(rx_crc_bad)
  );
endmodule

// File: rtl/flit_link_chk.sv
module flit_link_chk #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       in_ready,
  input logic                       ret_in_valid,
  input logic                       ret_in_retry,
  input logic                       rx_out_valid,
  input logic                       rx_cls_err,
  input logic                       ret_out_valid,
  input logic                       ret_out_retry,
  input logic [4:0]                 ret_out_seq,
  input logic [$clog2(DEPTH+1)-1:0] tx_occ,
  input logic                       tx_replay,
  input logic [4:0]                 rx_exp,
  input logic                       rx_crc_bad
);
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) tx_occ <= DEPTH); // R4
  AST_FULL_STALLS: assert property (@(posedge clk) disable iff (!rst_n) (tx_occ == DEPTH) |-> !in_ready); // R4
  AST_REPLAY_NEEDS_RETRY: assert property (@(posedge clk) disable iff (!rst_n) $rose(tx_replay) |-> $past(ret_in_valid && ret_in_retry)); // R6
  AST_CRC_BAD_RETRY: assert property (@(posedge clk) disable iff (!rst_n) rx_crc_bad |=> (ret_out_valid && ret_out_retry && !rx_out_valid)); // R5
  AST_ACK_SEQ: assert property (@(posedge clk) disable iff (!rst_n) (ret_out_valid && !ret_out_retry) |-> (ret_out_seq == rx_exp)); // R8
  AST_DELIVER_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n) rx_out_valid |-> (rx_exp == 5'($past(rx_exp) + 1'b1))); // R7
  AST_CLASS_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n) rx_cls_err |-> (!rx_out_valid && !ret_out_retry)); // R9
endmodule

bind flit_link flit_link_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready),
  .ret_in_valid(ret_in_valid), .ret_in_retry(ret_in_retry),
  .rx_out_valid(rx_out_valid), .rx_cls_err(rx_cls_err),
  .ret_out_valid(ret_out_valid), .ret_out_retry(ret_out_retry), .ret_out_seq(ret_out_seq),
  .tx_occ(tx_occ), .tx_replay(tx_replay), .rx_exp(rx_exp), .rx_crc_bad(rx_crc_bad)
);

// File: tb/tb_flit_link.sv
`timescale 1ns/1ps
module tb_flit_link;
  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, in_valid, in_ready, tx_flit_valid, rx_flit_valid, rx_out_valid, rx_cls_err;
  logic [2:0] in_cls, rx_out_cls;
  logic [63:0] in_data, rx_out_data;
  logic [79:0] tx_flit, rx_flit;
  logic ret_in_valid, ret_in_retry, ret_out_valid, ret_out_retry;
  logic [4:0] ret_in_seq, ret_out_seq;

  logic floop = 1'b1, cloop = 1'b1, corr_on = 1'b0, mon_on = 1'b1, seq_chk = 1'b0;
  logic d_fv = 1'b0, d_cv = 1'b0, d_cr = 1'b0;
  logic [79:0] d_f = '0;
  logic [4:0] d_cs = '0;
  int fcnt = 0, nchk = 0, nerr = 0, nd = 0, exp_m = 0, k_sent = 0, tx_k = 0, nretry = 0;
  logic [79:0] cmask;

  assign cmask = (corr_on && (fcnt % 5 == 4)) ? (80'd1 << (fcnt % 80)) : '0;
  assign rx_flit_valid = floop ? tx_flit_valid : d_fv;
  assign rx_flit = floop ? (tx_flit ^ cmask) : d_f;
  assign ret_in_valid = cloop ? ret_out_valid : d_cv;
  assign ret_in_retry = cloop ? ret_out_retry : d_cr;
  assign ret_in_seq = cloop ? ret_out_seq : d_cs;

  always @(posedge clk) if (floop && tx_flit_valid) fcnt <= fcnt + 1;

  flit_link dut (.*);

  function automatic logic [7:0] ref_crc(input logic [71:0] b);
    logic [79:0] v;
    v = {b, 8'h00};
    for (int i = 79; i >= 8; i--) if (v[i]) v[i -: 9] = v[i -: 9] ^ 9'h107;
    return v[7:0];
  endfunction

  function automatic logic [63:0] f_data(input int k);
    return (64'h9E3779B97F4A7C15 * 64'(k + 1)) ^ 64'(k);
  endfunction

  function automatic logic [79:0] mk(input int c, input int s, input logic [63:0] d, input logic [79:0] m);
    logic [71:0] b;
    b = {3'(c), 5'(s), d};
    return {ref_crc(b), b} ^ m;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [79:0] act, input logic [79:0] expv);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  always @(negedge clk) if (mon_on && rst_n) begin
    if (tx_flit_valid) begin
      chk(tx_flit[79:72] == ref_crc(tx_flit[71:0]), "R2 crc field", tx_flit[79:72], ref_crc(tx_flit[71:0]));
      if (seq_chk) begin
        chk(tx_flit[68:64] == 5'(tx_k) && tx_flit[71:69] == 3'(tx_k % 6) && tx_flit[63:0] == f_data(tx_k),
            "R1 R3 flit fields", tx_flit[71:0], {3'(tx_k % 6), 5'(tx_k), f_data(tx_k)});
        tx_k++;
      end
    end
    if (ret_out_valid && ret_out_retry) begin
      nretry++;
      chk(ret_out_seq == 5'(exp_m) && !rx_out_valid, "R5 retry seq", ret_out_seq, 5'(exp_m));
    end
    if (rx_out_valid) begin
      chk(rx_out_data == f_data(nd) && rx_out_cls == 3'(nd % 6), "R7 in-order payload", rx_out_data, f_data(nd));
      chk(ret_out_valid && !ret_out_retry && ret_out_seq == 5'(exp_m + 1), "R8 ack seq", ret_out_seq, 5'(exp_m + 1));
      nd++;
      exp_m++;
    end
  end

  task automatic try_send(input int maxw, output bit ok);
    int w = 0;
    @(negedge clk);
    in_valid = 1'b1; in_cls = 3'(k_sent % 6); in_data = f_data(k_sent);
    #1;
    while (!in_ready && w < maxw) begin @(negedge clk); #1; w++; end
    ok = in_ready;
    if (ok) begin @(negedge clk); k_sent++; end
    in_valid = 1'b0;
  endtask

  task automatic send_one();
    bit ok;
    try_send(5000, ok);
  endtask

  task automatic wait_nd(input int n);
    int w = 0;
    while (nd < n && w < 3000) begin @(negedge clk); w++; end
  endtask

  task automatic inject(input logic [79:0] f);
    @(negedge clk); d_fv = 1'b1; d_f = f;
    @(negedge clk); d_fv = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    nerr++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    bit ok;
    int acc, base, got;
    rst_n = 1'b0; in_valid = 1'b0; in_cls = '0; in_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready && !tx_flit_valid && !rx_out_valid && !ret_out_valid && !rx_cls_err, "R10 reset state",
        {in_ready, tx_flit_valid, rx_out_valid, ret_out_valid, rx_cls_err}, 5'b10000);

    // R1 R3 R8: clean loopback, wraps the sequence field
    seq_chk = 1'b1;
    for (int i = 0; i < 40; i++) send_one();
    wait_nd(40);
    chk(nd == 40, "R7 clean delivery count", nd, 40);
    seq_chk = 1'b0;

    // R5 R6: loopback with periodic corruption
    corr_on = 1'b1;
    for (int i = 0; i < 60; i++) send_one();
    wait_nd(100);
    corr_on = 1'b0;
    repeat (10) @(negedge clk);
    chk(nd == 100, "R7 exactly once under errors", nd, 100);
    chk(nretry > 0, "R6 retries exercised", nretry, 1);

    // R4: fill the retry buffer with acks cut off
    cloop = 1'b0;
    acc = 0;
    for (int i = 0; i < 9; i++) begin try_send(3, ok); if (ok) acc++; end
    chk(acc == 8, "R4 accepted before full", acc, 8);
    repeat (5) @(negedge clk);
    #1 chk(!in_ready, "R4 ready low when full", in_ready, 0);
    @(negedge clk); d_cv = 1'b1; d_cr = 1'b0; d_cs = 5'(exp_m - 4);
    @(negedge clk); d_cv = 1'b0;
    #1 chk(in_ready, "R4 cumulative ack frees", in_ready, 1);
    @(negedge clk); d_cv = 1'b1; d_cs = 5'(exp_m);
    @(negedge clk); d_cv = 1'b0;
    chk(nd == 108, "R7 delivery while full", nd, 108);

    // direct receiver checks
    mon_on = 1'b0; floop = 1'b0;
    for (int b = 0; b < 80; b++) begin
      inject(mk(1, exp_m, f_data(b), 80'd1 << b));
      chk(ret_out_valid && ret_out_retry && ret_out_seq == 5'(exp_m) && !rx_out_valid,
          "R5 single-bit error", {ret_out_valid, ret_out_retry, ret_out_seq}, {2'b11, 5'(exp_m)});
    end
    for (int c = 0; c < 8; c++) begin
      inject(mk(c, exp_m, f_data(500 + c), '0));
      if (c < 6)
        chk(rx_out_valid && rx_out_cls == 3'(c) && rx_out_data == f_data(500 + c) && !rx_cls_err &&
            ret_out_valid && !ret_out_retry && ret_out_seq == 5'(exp_m + 1),
            "R8 class delivered", {rx_out_cls, rx_out_data}, {3'(c), f_data(500 + c)});
      else
        chk(rx_cls_err && !rx_out_valid && ret_out_valid && !ret_out_retry && ret_out_seq == 5'(exp_m + 1),
            "R9 reserved class consumed", {rx_cls_err, rx_out_valid, ret_out_seq}, {2'b10, 5'(exp_m + 1)});
      exp_m++;
    end
    inject(mk(7, exp_m + 3, 64'h1, '0));
    chk(rx_cls_err && !ret_out_valid && !rx_out_valid, "R9 reserved out of order", {rx_cls_err, ret_out_valid}, 2'b10);
    @(negedge clk);
    chk(!rx_cls_err, "R9 single-cycle pulse", rx_cls_err, 0);
    inject(mk(2, exp_m - 1, 64'h2, '0));
    chk(!rx_out_valid && !ret_out_valid, "R7 duplicate dropped", {rx_out_valid, ret_out_valid}, 2'b00);
    inject(mk(2, exp_m + 1, 64'h3, '0));
    chk(!rx_out_valid && !ret_out_valid, "R7 ahead dropped", {rx_out_valid, ret_out_valid}, 2'b00);
    inject(mk(0, exp_m, 64'h4, '0));
    chk(rx_out_valid && rx_out_data == 64'h4 && ret_out_seq == 5'(exp_m + 1), "R7 expected still accepted",
        rx_out_data, 64'h4);
    exp_m++;

    // R6: transmitter replay on request
    base = k_sent;
    for (int i = 0; i < 3; i++) send_one();
    repeat (2) @(negedge clk);
    @(negedge clk); d_cv = 1'b1; d_cr = 1'b1; d_cs = 5'(base);
    #1 chk(!in_ready, "R6 ready low on retry", in_ready, 0);
    @(negedge clk); d_cv = 1'b0; d_cr = 1'b0;
    got = 0;
    for (int i = 0; i < 8; i++) begin
      if (tx_flit_valid && got < 3) begin
        chk(tx_flit[68:64] == 5'(base + got) && tx_flit[63:0] == f_data(base + got) &&
            tx_flit[79:72] == ref_crc(tx_flit[71:0]),
            "R6 replay order", tx_flit[71:0], {3'((base + got) % 6), 5'(base + got), f_data(base + got)});
        got++;
      end
      @(negedge clk);
    end
    chk(got == 3, "R6 replay length", got, 3);
    d_cv = 1'b1; d_cs = 5'(k_sent);
    @(negedge clk); d_cv = 1'b0;
    #1 chk(in_ready && !tx_flit_valid, "R6 idle after ack", {in_ready, tx_flit_valid}, 2'b10);

    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule